// File: doc/BRIEF.md
# Dual Fetch Buffer Prefetcher

This block sits between an instruction fetch requester and an instruction cache. It holds two fetch buffers. Each buffer has an aligned block address tag and a request number with a pending flag. When the requester offers a fetch PC, the PC is rounded down to the block size. The block size is 8 bytes in narrow mode and 16 bytes in wide mode. The buffer whose tag matches becomes the current buffer. If neither tag matches, a fixed default buffer is chosen. The other buffer is then made to hold the next sequential block.

Every retagged buffer gets a fresh request number from a single shared counter. A load request for that buffer is queued to the cache. The block raises a stall until two things hold: the current buffer's request has been answered, and any branch penalty handed in with the fetch has drained. The stall cycles of the latest fetch are reported on a counter output.

The cache answers a request by returning its request number. The cache storage itself is not part of this block.

Top module: `pf_dual_fetch`

## Requirements
- R1: The aligned address is the PC with its low 3 bits cleared (wide_mode_i=0, block 8 bytes) or its low 4 bits cleared (wide_mode_i=1, block 16 bytes). Every request address is an aligned block address.
- R2: If buffer b's tag equals the aligned PC, b is the current buffer. If neither tag matches, buffer 0 is the current buffer and is retagged. req_buf_o names the buffer a request refills.
- R3: A current buffer whose tag does not match is retagged to the aligned PC. Its load request is issued in the first cycle after the fetch is accepted, ahead of any other request.
- R4: The other buffer has index (current+1) mod 2. If its tag is not the aligned PC plus the block size, it is retagged to that address. Its request is issued in the cycle after the current buffer's request, or in the first cycle if the current buffer hit.
- R5: Request numbers come from one counter shared by both buffers. The counter is 0 after reset and advances by one for each request, in issue order.
- R6: stall_o stays high until the current buffer's pending request is answered by a response carrying its number. stall_o falls in the cycle after that response.
- R7: A response whose number matches no pending buffer has no effect on the stall or on the buffers.
- R8: A nonzero penalty_i sampled with an accepted fetch keeps stall_o high for at least that many cycles, counted from the cycle after acceptance. The penalty overlaps the fetch wait and is then cleared.
- R9: wait_cnt_o is cleared when a fetch is accepted. It then counts the cycles in which stall_o is high, and holds its value until the next accepted fetch.
- R10: After reset both tags are invalid, no request is pending, and stall_o, req_valid_o and wait_cnt_o are 0. The first fetch misses both buffers.
- R11: A fetch is accepted only in a cycle where fetch_valid_i is high and stall_o is low. At most one request is issued per cycle. stall_o stays high while any request of the fetch is still waiting to issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch PC offered |
| fetch_pc_i | input | ADDR_W | Fetch PC |
| wide_mode_i | input | 1 | 0: 8-byte blocks, 1: 16-byte blocks |
| penalty_i | input | PEN_W | Branch penalty cycles charged to this fetch |
| rsp_valid_i | input | 1 | Cache response valid |
| rsp_id_i | input | ID_W | Request number of the response |
| req_valid_o | output | 1 | Load request to the cache |
| req_addr_o | output | ADDR_W | Aligned block address of the request |
| req_id_o | output | ID_W | Request number |
| req_buf_o | output | 1 | Buffer being refilled |
| stall_o | output | 1 | Requester must wait |
| wait_cnt_o | output | CNT_W | Stall cycles of the latest fetch |

## Verification
Take the accepting edge as cycle 0. A current-buffer request is due in cycle 1. The sequential prefetch request is due in cycle 2, or in cycle 1 when the current buffer hit.

With a response latency of L cycles per request, the predicted stall lengths are:
- A miss stalls for max(P, L+1) cycles.
- A hit that still has to prefetch stalls for max(P, 1) cycles.
- A full hit stalls for P cycles.

The bench samples every output on the falling edge. After each stall ends, it waits out the latency, so every response has landed before it compares the logged requests and wait_cnt_o with values from its own two-buffer model.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned NBUF = 2;

  typedef enum logic {
    BLK_NARROW = 1'b0,
    BLK_WIDE   = 1'b1
  } blk_mode_e;
endpackage

// File: rtl/pf_fetch_buf.sv
module pf_fetch_buf #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [ID_W-1:0]   load_id_i,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_id_i,
  output logic              tag_vld_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ID_W-1:0]   id_o,
  output logic              pend_o
);
  logic rsp_hit;
  assign rsp_hit = rsp_valid_i && pend_o && (rsp_id_i == id_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_vld_o <= 1'b0;
      tag_o     <= '0;
      id_o      <= '0;
      pend_o    <= 1'b0;
    end else if (load_i) begin
      tag_vld_o <= 1'b1;
      tag_o     <= load_addr_i;
      id_o      <= load_id_i;
      pend_o    <= 1'b1;
    end else if (rsp_hit) begin
      pend_o    <= 1'b0;
    end
  end

  AST_RSP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && pend_o && rsp_id_i == id_o && !load_i) |=> !pend_o); // R6
  AST_FOREIGN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rsp_valid_i && rsp_id_i != id_o) |=> ($stable(pend_o) && $stable(tag_o))); // R7
  AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(tag_o) && $stable(tag_vld_o))); // R2
endmodule

// File: rtl/pf_issue.sv
module pf_issue (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_i,
  input  logic       cur_i,
  output logic       req_valid_o,
  output logic       req_buf_o,
  output logic       pending_o
);
  logic [1:0] iss_q;
  logic [1:0] grant;

  // current buffer drains ahead of the prefetch buffer
  always_comb begin
    grant = '0;
    if (iss_q[cur_i])       grant[cur_i]  = 1'b1;
    else if (iss_q[!cur_i]) grant[!cur_i] = 1'b1;
  end

  assign req_valid_o = |grant;
  assign req_buf_o   = grant[1];
  assign pending_o   = |iss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iss_q <= '0;
    else         iss_q <= (iss_q & ~grant) | set_i;
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R11
  AST_CUR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_q[cur_i] && req_valid_o) |-> (req_buf_o == cur_i)); // R3
  AST_NO_SET_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 2'b00) |-> (iss_q == 2'b00)); // R11
endmodule

// File: rtl/pf_wait_ctr.sv
module pf_wait_ctr #(
  parameter int unsigned PEN_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [PEN_W-1:0] pen_i,
  input  logic             busy_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] wait_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PEN_W-1:0] pen_q;

  assign stall_o = (pen_q != '0) || busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q  <= '0;
      wait_o <= '0;
    end else if (accept_i) begin
      pen_q  <= pen_i;
      wait_o <= '0;
    end else begin
      if (pen_q != '0) pen_q <= pen_q - 1'b1;
      if (stall_o && wait_o != CNT_MAX) wait_o <= wait_o + 1'b1;
    end
  end

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !accept_i) |=> $stable(wait_o)); // R9
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !stall_o); // R11
endmodule

// File: rtl/pf_dual_fetch.sv
module pf_dual_fetch
  import pf_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned ID_W         = 8,
  parameter int unsigned PEN_W        = 4,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned NARROW_BYTES = 8,
  parameter int unsigned WIDE_BYTES   = 16,
  parameter bit          DEF_BUF      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              wide_mode_i,
  input  logic [PEN_W-1:0]  penalty_i,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_id_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ID_W-1:0]   req_id_o,
  output logic              req_buf_o,
  output logic              stall_o,
  output logic [CNT_W-1:0]  wait_cnt_o
);
  localparam logic [ADDR_W-1:0] NARROW_SZ = ADDR_W'(NARROW_BYTES);
  localparam logic [ADDR_W-1:0] WIDE_SZ   = ADDR_W'(WIDE_BYTES);

  logic              accept;
  logic [ADDR_W-1:0] blk_sz, aligned, next_blk;
  logic [NBUF-1:0]   tag_vld, pend, hit, load;
  logic [ADDR_W-1:0] tag   [NBUF];
  logic [ID_W-1:0]   bid   [NBUF];
  logic [ADDR_W-1:0] ld_addr [NBUF];
  logic [ID_W-1:0]   ld_id [NBUF];
  logic              cur_sel, pre_sel, cur_found, pre_hit;
  logic              load_cur, load_pre;
  logic              cur_q;
  logic [ID_W-1:0]   ctr_q;
  logic              iss_pending, busy;

  assign accept   = fetch_valid_i && !stall_o;
  assign blk_sz   = (blk_mode_e'(wide_mode_i) == BLK_WIDE) ? WIDE_SZ : NARROW_SZ;
  assign aligned  = fetch_pc_i & ~(blk_sz - 1'b1);
  assign next_blk = aligned + blk_sz;

  // lowest matching buffer wins; default buffer on a miss
  always_comb begin
    cur_sel   = DEF_BUF;
    cur_found = 1'b0;
    for (int b = 0; b < NBUF; b++) begin
      if (hit[b] && !cur_found) begin
        cur_sel   = b[0];
        cur_found = 1'b1;
      end
    end
  end

  assign pre_sel  = !cur_sel;
  assign pre_hit  = tag_vld[pre_sel] && (tag[pre_sel] == next_blk);
  assign load_cur = accept && !cur_found;
  assign load_pre = accept && !pre_hit;

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      assign hit[b]     = tag_vld[b] && (tag[b] == aligned);
      assign load[b]    = (load_cur && cur_sel == b[0]) || (load_pre && pre_sel == b[0]);
      assign ld_addr[b] = (cur_sel == b[0]) ? aligned : next_blk;
      assign ld_id[b]   = (cur_sel == b[0]) ? ctr_q : ctr_q + ID_W'(load_cur);

      pf_fetch_buf #(
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W)
      ) u_buf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load[b]),
        .load_addr_i (ld_addr[b]),
        .load_id_i   (ld_id[b]),
        .rsp_valid_i (rsp_valid_i),
        .rsp_id_i    (rsp_id_i),
        .tag_vld_o   (tag_vld[b]),
        .tag_o       (tag[b]),
        .id_o        (bid[b]),
        .pend_o      (pend[b])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= DEF_BUF;
      ctr_q <= '0;
    end else if (accept) begin
      cur_q <= cur_sel;
      ctr_q <= ctr_q + ID_W'(load_cur) + ID_W'(load_pre);
    end
  end

  pf_issue u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (load),
    .cur_i       (cur_q),
    .req_valid_o (req_valid_o),
    .req_buf_o   (req_buf_o),
    .pending_o   (iss_pending)
  );

  assign req_addr_o = tag[req_buf_o];
  assign req_id_o   = bid[req_buf_o];
  assign busy       = pend[cur_q] || iss_pending;

  pf_wait_ctr #(
    .PEN_W(PEN_W),
    .CNT_W(CNT_W)
  ) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .pen_i    (penalty_i),
    .busy_i   (busy),
    .stall_o  (stall_o),
    .wait_o   (wait_cnt_o)
  );

  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[2:0] == 3'b000)); // R1
  AST_ID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(req_valid_o)) |-> (req_id_o == $past(req_id_o) + 1'b1)); // R5
  AST_PEN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && penalty_i != '0) |=> stall_o); // R8
  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit == '0) |=> (req_valid_o && req_buf_o == DEF_BUF)); // R2
  AST_CUR_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && $past(stall_o)) |-> !pend[cur_q]); // R6
endmodule

// File: tb/sim_pf_dual_fetch.sv
module sim_pf_dual_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 8;
  localparam int PEN_W  = 4;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              wide = 1'b0;
  logic [PEN_W-1:0]  pen = '0;
  logic              rsp_valid = 1'b0;
  logic [ID_W-1:0]   rsp_id = '0;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [ID_W-1:0]   req_id;
  logic              req_buf;
  logic              stall;
  logic [CNT_W-1:0]  wait_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_dual_fetch u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .wide_mode_i(wide), .penalty_i(pen), .rsp_valid_i(rsp_valid), .rsp_id_i(rsp_id),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_id_o(req_id), .req_buf_o(req_buf),
    .stall_o(stall), .wait_cnt_o(wait_cnt)
  );

  int checks = 0;
  int fails  = 0;
  int lat    = 3;
  bit inj_arm = 1'b0;
  bit done   = 1'b0;

  // cache model and request log
  int          obs_n = 0;
  logic [31:0] obs_addr [4];
  int          obs_id   [4];
  int          obs_buf  [4];
  bit          sv  [8];
  int          sc  [8];
  int          sid [8];

  initial for (int s = 0; s < 8; s++) sv[s] = 1'b0;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    for (int s = 0; s < 8; s++) begin
      if (sv[s]) begin
        sc[s] = sc[s] - 1;
        if (sc[s] == 0) begin
          rsp_valid = 1'b1;
          rsp_id    = sid[s][ID_W-1:0];
          sv[s]     = 1'b0;
        end
      end
    end
    if (rst_n && req_valid) begin
      if (obs_n < 4) begin
        obs_addr[obs_n] = req_addr;
        obs_id[obs_n]   = int'(req_id);
        obs_buf[obs_n]  = int'(req_buf);
      end
      obs_n++;
      for (int s = 0; s < 8; s++)
        if (!sv[s]) begin sv[s] = 1'b1; sc[s] = lat; sid[s] = int'(req_id); break; end
      if (inj_arm) begin
        for (int s = 0; s < 8; s++)
          if (!sv[s]) begin sv[s] = 1'b1; sc[s] = 2; sid[s] = (int'(req_id) + 77) % 256; break; end
        inj_arm = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the two buffers
  logic [31:0] m_tag [2];
  bit          m_vld [2];
  int          m_ctr = 0;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_fetch(input logic [31:0] pc, input bit wm, input int p, input bit inject);
    logic [31:0] blk, al, pa;
    int cur, pre, e_n, exp_wait, scnt;
    bit hitc, hitp;
    logic [31:0] e_addr [2];
    int e_id [2];
    int e_buf [2];
    blk  = wm ? 32'd16 : 32'd8;
    al   = pc & ~(blk - 1);
    pa   = al + blk;
    hitc = 1'b1;
    if (m_vld[0] && m_tag[0] == al)      cur = 0;
    else if (m_vld[1] && m_tag[1] == al) cur = 1;
    else begin cur = 0; hitc = 1'b0; end
    pre  = 1 - cur;
    hitp = m_vld[pre] && m_tag[pre] == pa;
    e_n = 0;
    if (!hitc) begin
      e_addr[e_n] = al; e_id[e_n] = m_ctr % 256; e_buf[e_n] = cur; e_n++;
      m_ctr++; m_tag[cur] = al; m_vld[cur] = 1'b1;
    end
    if (!hitp) begin
      e_addr[e_n] = pa; e_id[e_n] = m_ctr % 256; e_buf[e_n] = pre; e_n++;
      m_ctr++; m_tag[pre] = pa; m_vld[pre] = 1'b1;
    end
    exp_wait = !hitc ? imax(p, lat + 1) : (!hitp ? imax(p, 1) : p);

    @(negedge clk);
    obs_n       = 0;
    inj_arm     = inject;
    fetch_pc    = pc;
    wide        = wm;
    pen         = PEN_W'(p);
    fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    scnt = 0;
    while (stall) begin
      scnt++;
      @(negedge clk);
    end
    repeat (lat + 3) @(negedge clk);

    check(obs_n == e_n, "R3/R4 request count", obs_n, e_n);
    for (int i = 0; i < e_n && i < obs_n; i++) begin
      check(obs_addr[i] == e_addr[i], "R1 request address", obs_addr[i], e_addr[i]);
      check(obs_buf[i] == e_buf[i], "R2 request buffer", obs_buf[i], e_buf[i]);
      check(obs_id[i] == e_id[i], "R5 request number", obs_id[i], e_id[i]);
    end
    if (inject) check(scnt == exp_wait, "R7 stall with stray response", scnt, exp_wait);
    else if (p > 0) check(scnt == exp_wait, "R8 stall with penalty", scnt, exp_wait);
    else check(scnt == exp_wait, "R6 stall length", scnt, exp_wait);
    check(int'(wait_cnt) == exp_wait, "R9 wait count", wait_cnt, exp_wait);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_pc;
    bit wm;
    void'($urandom(32'd2024));
    m_vld[0] = 1'b0; m_vld[1] = 1'b0;
    m_tag[0] = '0;   m_tag[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall == 1'b0, "R10 stall after reset", stall, 0);
    check(req_valid == 1'b0, "R10 no request after reset", req_valid, 0);
    check(wait_cnt == '0, "R10 wait count after reset", wait_cnt, 0);

    lat = 3;
    do_fetch(32'h104, 1'b0, 0, 1'b0);   // R10 first fetch misses both buffers
    do_fetch(32'h108, 1'b0, 0, 1'b0);   // R2 hit in buffer 1, R4 prefetch into buffer 0
    do_fetch(32'h10C, 1'b0, 0, 1'b0);   // full hit, zero wait
    do_fetch(32'h10A, 1'b0, 5, 1'b0);   // R8 penalty only
    do_fetch(32'h800, 1'b0, 10, 1'b0);  // R8 penalty longer than miss
    do_fetch(32'h1237, 1'b1, 0, 1'b0);  // R1 wide alignment
    do_fetch(32'h1245, 1'b1, 0, 1'b0);  // wide sequential
    lat = 6;
    do_fetch(32'h3000, 1'b0, 0, 1'b1);  // R7 stray response ignored
    lat = 1;
    do_fetch(32'h4000, 1'b0, 0, 1'b0);

    last_pc = 32'h2000;
    wm = 1'b0;
    for (int n = 0; n < 300; n++) begin
      int r, p;
      logic [31:0] pc;
      if ($urandom % 8 == 0) wm = ~wm;
      r = $urandom % 4;
      if (r < 2)       pc = last_pc + (wm ? 32'd16 : 32'd8);
      else if (r == 2) pc = last_pc + ($urandom % 8);
      else             pc = 32'h2000 + ($urandom % 16) * 8;
      p   = ($urandom % 3 == 0) ? int'($urandom % 12) : 0;
      lat = 1 + int'($urandom % 6);
      do_fetch(pc, wm, p, (lat >= 4) && ($urandom % 5 == 0));
      last_pc = pc;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule